// File: doc/BRIEF.md
# Link Pulse Burst Code Word Codec

This block carries one 16-bit link code word between two link partners as a burst of short link pulses. A burst is a train of 33 equally spaced pulse slots. The slots with even index (counted from 0) hold framing pulses that are always present. The slots with odd index hold one word bit each: a pulse means 1 and an empty slot means 0.

On the transmit side the block accepts an 11-bit ability field and a start strobe. It inserts the fixed 5-bit selector code in the low bits of the word. It then drives a one-cycle pulse request for each pulse of the burst and holds off further starts until a quiet gap has elapsed. On the receive side it takes a one-cycle pulse-detect strobe. It tracks the framing pulses against a timing window, samples each data window, and presents the recovered word with a one-cycle valid strobe. A burst with a framing pulse missing from its window is dropped. All spacings are parameters counted in clock cycles: `HALF_CYC` is the time from a framing pulse to the following data slot, `TOL_CYC` is the receive tolerance, and `GAP_CYC` is the quiet time between bursts.

Top module: `flp_codec`

## Requirements
- R1: After a synchronous reset, `tx_pulse`, `tx_busy` and `rx_valid` are 0 and `rx_word` is 0, even if a burst was in progress.
- R2: A `tx_start` sampled while `tx_busy` is 0 yields a pulse in the next cycle. It then yields pulses only at slot k = 0..32, at k·`HALF_CYC` cycles after that first pulse. Every even slot carries a pulse, so each burst has 17 framing pulses.
- R3: Odd slot 2i+1 carries a pulse exactly when bit i of the transmitted word is 1. Bit 0 is sent first and bit 15 last.
- R4: The transmitted word is {`tx_ability`[10:0], 5'b00001}: bits 4:0 are always the selector code 00001, whatever the ability input is.
- R5: `tx_busy` is 1 from the cycle after an accepted start through `GAP_CYC` cycles after the cycle of the last pulse, and 0 in the cycle after that. A `tx_start` while busy has no effect on the pulse stream.
- R6: The receiver starts a burst on a pulse while idle. A valid burst has 16 further framing pulses, each at 2·`HALF_CYC` ± `TOL_CYC` cycles after the framing pulse before it. Such a burst produces exactly one `rx_valid` pulse, one cycle long.
- R7: Received bit i is 1 exactly when a pulse falls `HALF_CYC` ± `TOL_CYC` cycles after framing pulse i, and 0 otherwise. `rx_word` bit 0 holds the first data slot.
- R8: A pulse that lands outside both the data window and the framing window during a burst has no effect on the recovered word or on `rx_valid`.
- R9: If no pulse arrives within 2·`HALF_CYC` + `TOL_CYC` cycles of a framing pulse, the burst is dropped with no `rx_valid` and the receiver goes idle.
- R10: `rx_valid` rises in the cycle after the cycle in which the 17th framing pulse is detected, and `rx_word` holds the recovered word while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_start | input | 1 | Start strobe for one transmit burst |
| tx_ability | input | 11 | Ability bits placed in word bits 15:5 |
| tx_pulse | output | 1 | One-cycle request to emit a link pulse |
| tx_busy | output | 1 | Burst or post-burst gap in progress |
| rx_det | input | 1 | One-cycle strobe per detected line pulse |
| rx_valid | output | 1 | One-cycle strobe: a complete burst was received |
| rx_word | output | 16 | Last recovered code word |

## Verification
The assertions take two things as given. First, `HALF_CYC` is at least 2, so two transmit pulses can never fall in adjacent cycles. Second, `TOL_CYC` is below half of `HALF_CYC`, so the data and framing windows never overlap. The bench uses 20 and 4, which meets both. The receive checks treat `rx_det` as a strobe one cycle wide. The bench only drives isolated single-cycle strobes or feeds the transmitter output back into the receiver, which gives the same kind of stream. No stray pulse is placed after the final framing pulse of a burst, because the receiver would rightly read it as the start of a new burst.

// File: rtl/flp_pkg.sv
// Shared types and constants for the link pulse burst codec.
// Assumes a 16-bit code word whose low five bits are a fixed selector.
package flp_pkg;
    localparam int WORD_W = 16;
    localparam int SEL_W  = 5;
    localparam int ABIL_W = WORD_W - SEL_W;
    localparam int SLOTS  = 2 * WORD_W + 1;
    localparam logic [SEL_W-1:0] SEL_CODE = 5'b00001;

    typedef enum logic [1:0] {TX_IDLE, TX_BURST, TX_GAP} tx_state_e;
    typedef enum logic       {RX_IDLE, RX_RUN} rx_state_e;
endpackage

// File: rtl/flp_tx.sv
// Transmit half: turns an ability field into a pulse-request stream.
// Slot k is emitted k*HALF_CYC cycles after the first pulse. Even slots are
// framing pulses and odd slot 2i+1 carries word bit i.
// Assumes HALF_CYC >= 2 and GAP_CYC >= 1.
module flp_tx
    import flp_pkg::*;
#(
    parameter int HALF_CYC = 12500,
    parameter int GAP_CYC  = 3200000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ABIL_W-1:0] ability,
    output logic              pulse,
    output logic              busy
);
    localparam int HW = $clog2(HALF_CYC + 1);
    localparam int GW = $clog2(GAP_CYC + 1);
    localparam int PW = $clog2(SLOTS + 1);

    tx_state_e          state;
    logic [HW-1:0]      cnt;
    logic [PW-1:0]      pos;
    logic [GW-1:0]      gcnt;
    logic [WORD_W-1:0]  word;

    // Sequencer: idle -> burst of SLOTS positions -> quiet gap -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            cnt   <= '0;
            pos   <= '0;
            gcnt  <= '0;
            word  <= '0;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (start) begin
                        word  <= {ability, SEL_CODE};
                        pos   <= '0;
                        cnt   <= '0;
                        state <= TX_BURST;
                    end
                end
                TX_BURST: begin
                    if (pos == PW'(SLOTS - 1) && cnt == '0) begin
                        state <= TX_GAP;
                        gcnt  <= '0;
                    end else if (cnt == HW'(HALF_CYC - 1)) begin
                        cnt <= '0;
                        pos <= pos + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                TX_GAP: begin
                    if (gcnt == GW'(GAP_CYC - 1)) state <= TX_IDLE;
                    else                          gcnt  <= gcnt + 1'b1;
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // Pulse request: framing on even slots, data bit on odd slots.
    always_comb begin
        pulse = (state == TX_BURST) && (cnt == '0) &&
                (!pos[0] || word[pos[4:1]]);
    end

    assign busy = (state != TX_IDLE);

    assert_pulse_inside_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> busy);
    assert_pulses_never_adjacent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
    assert_start_gives_first_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> pulse);
    assert_busy_blocks_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state == TX_BURST && cnt != '0) |=> $stable(word));
endmodule

// File: rtl/flp_rx.sv
// Receive half: recovers a code word from a stream of pulse-detect strobes.
// It times each pulse from the last accepted framing pulse. A pulse at
// HALF_CYC +/- TOL_CYC sets the current bit. A pulse at 2*HALF_CYC +/- TOL_CYC
// is the next framing pulse. Other pulses are ignored. Silence past the
// framing window drops the burst.
// Assumes TOL_CYC < HALF_CYC/2, so the two windows never overlap.
module flp_rx
    import flp_pkg::*;
#(
    parameter int HALF_CYC = 12500,
    parameter int TOL_CYC  = 1600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              det,
    output logic              valid,
    output logic [WORD_W-1:0] word
);
    localparam int LIM = 2 * HALF_CYC + TOL_CYC;
    localparam int TW  = $clog2(LIM + 1);
    localparam logic [TW-1:0] D_LO = TW'(HALF_CYC - TOL_CYC);
    localparam logic [TW-1:0] D_HI = TW'(HALF_CYC + TOL_CYC);
    localparam logic [TW-1:0] F_LO = TW'(2 * HALF_CYC - TOL_CYC);
    localparam logic [TW-1:0] F_HI = TW'(LIM);

    rx_state_e          state;
    logic [TW-1:0]      t;
    logic [3:0]         fcnt;
    logic               bitcur;
    logic [WORD_W-1:0]  shreg;
    logic               in_data, in_frame;

    // Window decode on the time since the last framing pulse.
    always_comb begin
        in_data  = (t >= D_LO) && (t <= D_HI);
        in_frame = (t >= F_LO) && (t <= F_HI);
    end

    // Burst tracker: framing windows, data sampling and word assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RX_IDLE;
            t      <= '0;
            fcnt   <= '0;
            bitcur <= 1'b0;
            shreg  <= '0;
            word   <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (det) begin
                        state  <= RX_RUN;
                        t      <= TW'(1);
                        fcnt   <= '0;
                        bitcur <= 1'b0;
                    end
                end
                RX_RUN: begin
                    if (det && in_frame) begin
                        t      <= TW'(1);
                        shreg  <= {bitcur, shreg[WORD_W-1:1]};
                        bitcur <= 1'b0;
                        fcnt   <= fcnt + 1'b1;
                        if (fcnt == 4'd15) begin
                            word  <= {bitcur, shreg[WORD_W-1:1]};
                            valid <= 1'b1;
                            state <= RX_IDLE;
                        end
                    end else if (t == F_HI) begin
                        state <= RX_IDLE;
                    end else begin
                        t <= t + 1'b1;
                        if (det && in_data) bitcur <= 1'b1;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    assert_valid_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    assert_valid_follows_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(det));
    assert_timer_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_RUN) |-> (t <= F_HI));
endmodule

// File: rtl/flp_codec.sv
// Top of the link pulse burst codec: independent transmit and receive halves
// sharing one clock. All timing is in clock cycles, set by parameters.
module flp_codec
    import flp_pkg::*;
#(
    parameter int HALF_CYC = 12500,
    parameter int TOL_CYC  = 1600,
    parameter int GAP_CYC  = 3200000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_start,
    input  logic [10:0] tx_ability,
    output logic        tx_pulse,
    output logic        tx_busy,
    input  logic        rx_det,
    output logic        rx_valid,
    output logic [15:0] rx_word
);
    // Transmit half.
    flp_tx #(.HALF_CYC(HALF_CYC), .GAP_CYC(GAP_CYC)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tx_start),
        .ability (tx_ability),
        .pulse   (tx_pulse),
        .busy    (tx_busy)
    );

    // Receive half.
    flp_rx #(.HALF_CYC(HALF_CYC), .TOL_CYC(TOL_CYC)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .det   (rx_det),
        .valid (rx_valid),
        .word  (rx_word)
    );
endmodule

// File: tb/flp_codec_bench.sv
module flp_codec_bench;
    localparam int H = 20;
    localparam int T = 4;
    localparam int G = 50;
    localparam int NV = 8;
    // {word, frame spacing, data offset, dropped framing index, stray flag}
    localparam logic [47:0] VEC [NV] = '{
        {16'hA5C3, 8'd40, 8'd20, 8'd0,  8'd0},
        {16'hFFFF, 8'd44, 8'd24, 8'd0,  8'd0},
        {16'h0001, 8'd36, 8'd16, 8'd0,  8'd0},
        {16'h5A5A, 8'd40, 8'd25, 8'd0,  8'd0},
        {16'h1234, 8'd40, 8'd20, 8'd0,  8'd1},
        {16'hBEEF, 8'd45, 8'd20, 8'd0,  8'd0},
        {16'hC0DE, 8'd40, 8'd20, 8'd7,  8'd0},
        {16'h8000, 8'd40, 8'd20, 8'd16, 8'd0}
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        tx_start = 0;
    logic [10:0] tx_ability = '0;
    logic        tx_pulse, tx_busy, rx_valid;
    logic [15:0] rx_word;
    logic        drv = 0;
    logic        lb = 0;
    logic        rx_det;
    logic        sched [0:1023];
    int          n_chk = 0;
    int          n_fail = 0;

    assign rx_det = lb ? tx_pulse : drv;

    always #2.5 clk = ~clk;

    flp_codec #(.HALF_CYC(H), .TOL_CYC(T), .GAP_CYC(G)) u_flp_codec (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_ability(tx_ability),
        .tx_pulse(tx_pulse), .tx_busy(tx_busy), .rx_det(rx_det),
        .rx_valid(rx_valid), .rx_word(rx_word)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Transmit one burst with loopback into the receiver and check the stream.
    task automatic run_tx(input logic [10:0] ab);
        logic [15:0] exp_w = {ab, 5'b00001};
        logic [15:0] rec = '0;
        int nframe = 0, nbad = 0, vat = -1;
        logic [15:0] vword = '0;
        lb = 1;
        @(negedge clk);
        tx_ability = ab;
        tx_start = 1;
        @(posedge clk);
        for (int j = 0; j <= 32*H + G + 2; j++) begin
            @(negedge clk);
            tx_start = (j == 5);
            tx_ability = ~ab;
            if (tx_pulse) begin
                if (j % H != 0 || j > 32*H) nbad++;
                else if ((j / H) % 2 == 0) nframe++;
                else rec[(j/H - 1)/2] = 1'b1;
            end
            if (rx_valid) begin vat = j; vword = rx_word; end
            if (j == 32*H + G) check(tx_busy == 1, "R5 busy through gap", tx_busy, 1);
            if (j == 32*H + G + 1) check(tx_busy == 0, "R5 busy drops after gap", tx_busy, 0);
        end
        check(nframe == 17, "R2 framing pulse count", nframe, 17);
        check(nbad == 0, "R2 R5 pulses off slot", nbad, 0);
        check(rec == exp_w, "R3 R4 transmitted word", rec, exp_w);
        check(vat == 32*H + 1, "R10 loopback valid timing", vat, 32*H + 1);
        check(vword == exp_w, "R6 loopback word", vword, exp_w);
        lb = 0;
    endtask

    // Drive a synthetic receive burst from one table entry.
    task automatic run_rx(input logic [47:0] v);
        logic [15:0] w = v[47:32];
        int sp = int'(v[31:24]);
        int dof = int'(v[23:16]);
        int drop = int'(v[15:8]);
        bit stray = v[0];
        bit exp_v = (sp >= 2*H - T) && (sp <= 2*H + T) && (drop == 0);
        logic [15:0] exp_w = (dof >= H - T && dof <= H + T) ? w : 16'h0;
        int nv = 0, vat = -1;
        logic [15:0] vword = '0;
        int last = 16*sp + 2*H + T + 8;
        for (int c = 0; c < 1024; c++) sched[c] = 1'b0;
        for (int k = 0; k <= 16; k++) begin
            if (k != drop || drop == 0) sched[k*sp] = 1'b1;
            if (k < 16 && w[k]) sched[k*sp + dof] = 1'b1;
            if (k < 16 && stray) sched[k*sp + 3] = 1'b1;
        end
        for (int c = 0; c <= last; c++) begin
            @(negedge clk);
            if (rx_valid) begin nv++; vat = c; vword = rx_word; end
            drv = (c < last) ? sched[c] : 1'b0;
        end
        // R6 R9: exactly one valid for a good burst, none for a broken one
        check(nv == int'(exp_v), "R6 R9 valid count", nv, int'(exp_v));
        if (exp_v) begin
            check(vat == 16*sp + 1, "R10 valid timing", vat, 16*sp + 1);
            check(vword == exp_w, "R7 R8 received word", vword, exp_w);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(tx_pulse == 0, "R1 reset tx_pulse", tx_pulse, 0);
        check(tx_busy == 0, "R1 reset tx_busy", tx_busy, 0);
        check(rx_valid == 0, "R1 reset rx_valid", rx_valid, 0);
        check(rx_word == 0, "R1 reset rx_word", rx_word, 0);

        for (int i = 0; i < NV; i++) run_rx(VEC[i]);

        run_tx(11'h5A3);
        run_tx(11'h000);
        run_tx(11'h7FF);

        // R1: reset in the middle of a transmit burst
        @(negedge clk);
        tx_start = 1;
        @(negedge clk);
        tx_start = 0;
        repeat (50) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        check(tx_busy == 0, "R1 reset mid-burst busy", tx_busy, 0);
        check(tx_pulse == 0, "R1 reset mid-burst pulse", tx_pulse, 0);
        check(rx_word == 0, "R1 reset clears rx_word", rx_word, 0);
        repeat (2*H) @(negedge clk);
        check(tx_busy == 0, "R1 stays idle after reset", tx_busy, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule